// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block provides three independent 16-bit down-counting channels behind a small byte-wide register interface. Each channel has its own count clock, gate input and output pin. Software first writes a control byte that names a channel, sets how the 16-bit count is moved over the 8-bit bus, and picks one of six output modes. It then writes the count. The output modes are: a level that rises at terminal count, a one-shot that the gate can retrigger, a periodic one-clock low pulse, a square wave, and two one-clock strobes. One strobe starts when the count is written and the other starts on a gate edge.

Everything runs in one system clock domain. Each channel clock and gate input is sampled by that clock. A rising edge on a channel clock is one count step. Software can read the current count back through the same byte path that it uses for writes. In the two-byte format, one toggle per channel alternates low and high bytes. Reads and writes share this toggle.

Top module: `ivt3_timer`

## Requirements
- R1: With `sel` high, `addr` 0, 1 and 2 reach channels 0, 1 and 2, and `addr` 3 reaches the control byte. Accesses with `sel` low have no effect. Reads of `addr` 3 return 0. A control byte whose bits 7:6 are 11 is ignored.
- R2: Control byte bits 5:4 set the access format. 01 means low byte only, with the high byte written as 0. 10 means high byte only, with the low byte written as 0. 11 means low byte then high byte, alternating through a per-channel toggle that both reads and writes advance. Reads return the current count in the same format. A control byte with bits 5:4 equal to 00 is ignored.
- R3: Mode 0 (bits 3:1 = 000): the output goes low when the control byte is written and stays low after the count n is loaded. It goes high after n gated count steps and holds high until the channel is reprogrammed.
- R4: Mode 1 (001): after loading, the output stays high until a rising gate edge. It then goes low and returns high after n count steps. A further rising gate edge restarts the full count. Gate level does not pause counting.
- R5: Mode 2 (010): the output is high. After step k it is low exactly when k mod n = n-1, which gives one low step every n steps, with automatic reload.
- R6: Mode 3 (011): the output is high for ceil(n/2) steps and then low for floor(n/2) steps, repeating. It starts high at load. n must be at least 2.
- R7: Mode 4 (100): counting starts when the count is written. The output is high, goes low for exactly one count step after step n, then stays high.
- R8: Mode 5 (101): counting starts on a rising gate edge, and gate level is then ignored. The output goes low for one step after step n. A new gate edge restarts the count.
- R9: In modes 0, 2, 3 and 4, count steps with the gate low are ignored. Both the count and the output hold.
- R10: Writing a control byte stops that channel until a full count is loaded. It resets the byte toggle and sets the output low for mode 0 and high otherwise. Mode codes 110 and 111 act as 010 and 011.
- R11: A loaded count of 0 means 65536. The first count step yields a read value of 0xFFFF.
- R12: After reset all outputs are high, all counts read 0, and each channel uses the two-byte format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Block select, active high |
| rd_en | input | 1 | Read strobe, one system clock per byte |
| wr_en | input | 1 | Write strobe, one system clock per byte |
| addr | input | 2 | Channel or control byte select |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid while selected |
| ch_clk | input | 3 | Per-channel count clocks; a rising edge is one step |
| ch_gate | input | 3 | Per-channel gate inputs |
| ch_out | output | 3 | Per-channel outputs |

## Verification
The bench sweeps the count for each mode and compares the output after every step with a closed formula. Mode 0 uses n from 1 to 6. Modes 2 and 3 use n from 2 to 9 across three periods, and the odd and even values of n separate the ceiling and floor split of the square wave. Modes 1, 4 and 5 are swept over short counts, which separates write-started strobes from gate-started strobes, and a mid-count gate edge shows that retriggering restarts the count. Separate patterns cover the following: each access format with readback, toggle alternation, the ignored format and channel codes, deselected writes, a gate held low, reprogramming a channel in mid-count, and a zero count.

// File: rtl/ivt_pkg.sv
// Shared types for the interval timer.
// Assumes a fixed 16-bit count moved as two bytes.
package ivt_pkg;
    localparam int CNT_W = 16;

    typedef enum logic [2:0] {
        M_TC      = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } tmode_t;

    localparam logic [1:0] FMT_LO   = 2'b01;
    localparam logic [1:0] FMT_HI   = 2'b10;
    localparam logic [1:0] FMT_BOTH = 2'b11;

    // Fold the two spare mode codes onto rate and square.
    function automatic tmode_t fold_mode(input logic [2:0] m);
        if (m[2] && m[1]) return tmode_t'({1'b0, m[1:0]});
        return tmode_t'(m);
    endfunction

    // High-phase length of a square wave: ceil(n/2), where 0 means 65536.
    function automatic logic [CNT_W-1:0] half_hi(input logic [CNT_W-1:0] n);
        logic [CNT_W:0] m;
        m = (n == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, n};
        return CNT_W'((m + 1'b1) >> 1);
    endfunction

    // Low-phase length of a square wave: floor(n/2).
    function automatic logic [CNT_W-1:0] half_lo(input logic [CNT_W-1:0] n);
        logic [CNT_W:0] m;
        m = (n == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, n};
        return CNT_W'(m >> 1);
    endfunction
endpackage

// File: rtl/ivt_edge.sv
// Rising-edge detector for a vector of inputs already synchronous to clk.
// Assumes inputs change only between system clock edges.
module ivt_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Hold the previous sample of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/ivt_bus.sv
// Register-access decoder: turns the byte strobes into per-channel count
// writes, control-byte writes and read strobes.
// Assumes one system clock per strobe.
module ivt_bus #(
    parameter int NCH = 3
) (
    input  logic           sel,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic [1:0]     addr,
    input  logic [7:0]     wdata,
    output logic [NCH-1:0] cnt_wr,
    output logic [NCH-1:0] cfg_wr,
    output logic [NCH-1:0] rd_stb
);
    logic ctl_hit;
    logic unused_bit0;

    assign ctl_hit     = sel && wr_en && (addr == 2'b11) && (wdata[5:4] != 2'b00);
    assign unused_bit0 = wdata[0];

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign cnt_wr[i] = sel && wr_en && (addr == 2'(i));
        assign rd_stb[i] = sel && rd_en && (addr == 2'(i));
        assign cfg_wr[i] = ctl_hit && (wdata[7:6] == 2'(i));
    end
endmodule

// File: rtl/ivt_channel.sv
// One timer channel: count loading, byte readback and the six output modes.
// Assumes tick and gate_rise are single-cycle pulses in the clk domain.
module ivt_channel
    import ivt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       gate_lvl,
    input  logic       gate_rise,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_fmt,
    input  logic [2:0] cfg_mode,
    input  logic       cnt_wr,
    input  logic       rd_stb,
    input  logic [7:0] wdata,
    output logic       out,
    output logic [7:0] rbyte
);
    logic [2:0]       mode_q;
    logic [1:0]       fmt_q;
    logic             ptr_q;
    logic [7:0]       lo_hold;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             arm_q;
    logic             out_q;
    tmode_t           mode_e;
    logic             load_go;
    logic [CNT_W-1:0] load_val;
    logic             step;

    assign mode_e = fold_mode(mode_q);
    assign out    = out_q;
    assign step   = run_q && tick && (gate_lvl || arm_q);

    // Decide whether this write completes a count, and assemble it.
    always_comb begin
        load_go  = 1'b0;
        load_val = reload_q;
        if (cnt_wr) begin
            case (fmt_q)
                FMT_LO:  begin load_go = 1'b1; load_val = {8'h00, wdata}; end
                FMT_HI:  begin load_go = 1'b1; load_val = {wdata, 8'h00}; end
                default: begin load_go = ptr_q; load_val = {wdata, lo_hold}; end
            endcase
        end
    end

    // Return the count byte selected by the format and the toggle.
    always_comb begin
        case (fmt_q)
            FMT_LO:  rbyte = cnt_q[7:0];
            FMT_HI:  rbyte = cnt_q[15:8];
            default: rbyte = ptr_q ? cnt_q[15:8] : cnt_q[7:0];
        endcase
    end

    // Programming, loading, triggering and counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 3'd0;
            fmt_q    <= FMT_BOTH;
            ptr_q    <= 1'b0;
            lo_hold  <= '0;
            reload_q <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
            arm_q    <= 1'b0;
            out_q    <= 1'b1;
        end else if (cfg_wr) begin
            mode_q <= cfg_mode;
            fmt_q  <= cfg_fmt;
            ptr_q  <= 1'b0;
            run_q  <= 1'b0;
            arm_q  <= 1'b0;
            out_q  <= (fold_mode(cfg_mode) != M_TC);
        end else begin
            if (cnt_wr && fmt_q == FMT_BOTH) begin
                ptr_q <= ~ptr_q;
                if (!ptr_q) lo_hold <= wdata;
            end else if (rd_stb && fmt_q == FMT_BOTH) begin
                ptr_q <= ~ptr_q;
            end

            if (load_go) begin
                reload_q <= load_val;
                case (mode_e)
                    M_TC: begin
                        cnt_q <= load_val; run_q <= 1'b1; out_q <= 1'b0;
                    end
                    M_ONESHOT, M_HWSTB: begin
                        arm_q <= 1'b1; run_q <= 1'b0; out_q <= 1'b1;
                    end
                    M_SQUARE: begin
                        cnt_q <= half_hi(load_val); run_q <= 1'b1; out_q <= 1'b1;
                    end
                    default: begin
                        cnt_q <= load_val; run_q <= 1'b1; out_q <= 1'b1;
                    end
                endcase
            end else if (arm_q && gate_rise) begin
                cnt_q <= reload_q;
                run_q <= 1'b1;
                out_q <= (mode_e != M_ONESHOT);
            end else if (step) begin
                case (mode_e)
                    M_TC, M_ONESHOT: begin
                        if (cnt_q == 16'd1) begin
                            out_q <= 1'b1; run_q <= 1'b0; cnt_q <= '0;
                        end else cnt_q <= cnt_q - 16'd1;
                    end
                    M_RATE: begin
                        if (cnt_q == 16'd1) begin
                            cnt_q <= reload_q; out_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 16'd1; out_q <= (cnt_q != 16'd2);
                        end
                    end
                    M_SQUARE: begin
                        if (cnt_q == 16'd1) begin
                            out_q <= ~out_q;
                            cnt_q <= out_q ? half_lo(reload_q) : half_hi(reload_q);
                        end else cnt_q <= cnt_q - 16'd1;
                    end
                    default: begin
                        if (!out_q) begin
                            out_q <= 1'b1; run_q <= 1'b0;
                        end else if (cnt_q == 16'd1) begin
                            out_q <= 1'b0; cnt_q <= '0;
                        end else cnt_q <= cnt_q - 16'd1;
                    end
                endcase
            end
        end
    end

    AST_CFG_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!run_q && !arm_q)); // R10

    AST_TC_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == M_TC && out_q && !cfg_wr && !load_go) |=> out_q); // R3

    AST_RATE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == M_RATE && !out_q && step && !cfg_wr && !load_go) |=> out_q); // R5

    AST_STROBE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_e == M_SWSTB || mode_e == M_HWSTB) && !out_q && step
         && !cfg_wr && !load_go && !(arm_q && gate_rise)) |=> out_q); // R7

    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_e == M_TC || mode_e == M_RATE || mode_e == M_SQUARE || mode_e == M_SWSTB)
         && !gate_lvl && !cfg_wr && !cnt_wr) |=> ($stable(cnt_q) && $stable(out_q))); // R9
endmodule

// File: rtl/ivt3_timer.sv
// Three-channel programmable interval timer with a byte-wide register port.
// Assumes channel clocks and gates are synchronous to clk; one step per
// rising edge of a channel clock.
module ivt3_timer #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic [1:0]     addr,
    input  logic [7:0]     wdata,
    output logic [7:0]     rdata,
    input  logic [NCH-1:0] ch_clk,
    input  logic [NCH-1:0] ch_gate,
    output logic [NCH-1:0] ch_out
);
    logic [NCH-1:0] tick;
    logic [NCH-1:0] gate_rise;
    logic [NCH-1:0] cnt_wr;
    logic [NCH-1:0] cfg_wr;
    logic [NCH-1:0] rd_stb;
    logic [7:0]     rbyte [NCH];

    ivt_edge #(.W(NCH)) u_clk_edge (
        .clk(clk), .rst_n(rst_n), .lvl(ch_clk), .rise(tick)
    );

    ivt_edge #(.W(NCH)) u_gate_edge (
        .clk(clk), .rst_n(rst_n), .lvl(ch_gate), .rise(gate_rise)
    );

    ivt_bus #(.NCH(NCH)) u_bus (
        .sel(sel), .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cnt_wr(cnt_wr), .cfg_wr(cfg_wr), .rd_stb(rd_stb)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ivt_channel u_ch (
            .clk(clk), .rst_n(rst_n),
            .tick(tick[i]), .gate_lvl(ch_gate[i]), .gate_rise(gate_rise[i]),
            .cfg_wr(cfg_wr[i]), .cfg_fmt(wdata[5:4]), .cfg_mode(wdata[3:1]),
            .cnt_wr(cnt_wr[i]), .rd_stb(rd_stb[i]), .wdata(wdata),
            .out(ch_out[i]), .rbyte(rbyte[i])
        );
    end

    // Drive the selected channel's byte onto the read bus.
    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NCH; i++) begin
            if (sel && addr == 2'(i)) rdata = rbyte[i];
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cnt_wr, cfg_wr})); // R1
endmodule

// File: tb/sim_ivt3_timer.sv
module sim_ivt3_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] ch_clk = 3'b000;
    logic [2:0] ch_gate = 3'b011;
    logic [2:0] ch_out;
    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    ivt3_timer u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .ch_clk(ch_clk), .ch_gate(ch_gate), .ch_out(ch_out)
    );

    initial forever #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_sel(input logic s, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); sel = s; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr_sel(1'b1, a, d);
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); sel = 1'b1; rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); sel = 1'b0; rd_en = 1'b0;
    endtask

    // Control byte: channel, format, mode.
    task automatic cfg(input int ch, input int fmt, input int mode);
        bus_wr(2'b11, {2'(ch), 2'(fmt), 3'(mode), 1'b0});
    endtask

    task automatic load16(input int ch, input int n);
        bus_wr(2'(ch), 8'(n));
        bus_wr(2'(ch), 8'(n >> 8));
    endtask

    task automatic step(input int ch);
        @(negedge clk); ch_clk[ch] = 1'b1;
        @(negedge clk); ch_clk[ch] = 1'b0;
    endtask

    task automatic gate(input int ch, input logic v);
        @(negedge clk); ch_gate[ch] = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        @(negedge clk);
        chk("R12 outputs", ch_out, 3'b111);
        bus_rd(2'd0, rv); chk("R12 count lo", rv, 8'h00);
        bus_rd(2'd0, rv); chk("R12 count hi", rv, 8'h00);

        // R3: mode 0 sweep
        for (int n = 1; n <= 6; n++) begin
            cfg(0, 3, 0);
            chk("R3 low after control", ch_out[0], 1'b0);
            load16(0, n);
            for (int k = 1; k <= n + 2; k++) begin
                step(0);
                chk("R3 level", ch_out[0], (k >= n));
            end
        end

        // R5: mode 2 sweep
        for (int n = 2; n <= 9; n++) begin
            cfg(0, 3, 2);
            load16(0, n);
            for (int k = 1; k <= 3 * n; k++) begin
                step(0);
                chk("R5 rate", ch_out[0], ((k % n) != n - 1));
            end
        end

        // R6: mode 3 sweep, odd and even counts
        for (int n = 2; n <= 9; n++) begin
            cfg(0, 3, 3);
            load16(0, n);
            chk("R6 starts high", ch_out[0], 1'b1);
            for (int k = 1; k <= 3 * n; k++) begin
                step(0);
                chk("R6 square", ch_out[0], ((k % n) < (n + 1) / 2));
            end
        end

        // R7: mode 4 sweep
        for (int n = 1; n <= 5; n++) begin
            cfg(0, 3, 4);
            load16(0, n);
            for (int k = 1; k <= n + 3; k++) begin
                step(0);
                chk("R7 strobe", ch_out[0], (k != n));
            end
        end

        // R4: mode 1 on channel 2, gate starts low
        for (int n = 2; n <= 5; n++) begin
            gate(2, 1'b0);
            cfg(2, 3, 1);
            load16(2, n);
            step(2); step(2);
            chk("R4 waits for gate", ch_out[2], 1'b1);
            gate(2, 1'b1);
            chk("R4 low on gate", ch_out[2], 1'b0);
            for (int k = 1; k <= n + 1; k++) begin
                step(2);
                chk("R4 one-shot", ch_out[2], (k >= n));
            end
        end
        // R4: retrigger in mid-count, gate level ignored
        gate(2, 1'b0);
        cfg(2, 3, 1);
        load16(2, 4);
        gate(2, 1'b1);
        step(2); step(2);
        gate(2, 1'b0);
        gate(2, 1'b1);
        gate(2, 1'b0);
        step(2); step(2); step(2);
        chk("R4 retrigger restarts", ch_out[2], 1'b0);
        step(2);
        chk("R4 retrigger ends", ch_out[2], 1'b1);

        // R8: mode 5 on channel 2
        for (int n = 1; n <= 4; n++) begin
            gate(2, 1'b0);
            cfg(2, 3, 5);
            load16(2, n);
            step(2); step(2);
            chk("R8 waits for gate", ch_out[2], 1'b1);
            gate(2, 1'b1);
            gate(2, 1'b0);
            for (int k = 1; k <= n + 2; k++) begin
                step(2);
                chk("R8 strobe", ch_out[2], (k != n));
            end
        end

        // R9: gate low freezes mode 0 on channel 1
        cfg(1, 3, 0);
        load16(1, 3);
        gate(1, 1'b0);
        for (int k = 0; k < 5; k++) step(1);
        chk("R9 output held", ch_out[1], 1'b0);
        bus_rd(2'd1, rv); chk("R9 count held", rv, 8'h03);
        bus_rd(2'd1, rv);
        gate(1, 1'b1);
        step(1); step(1); step(1);
        chk("R9 resumes", ch_out[1], 1'b1);

        // R2: access formats and byte toggle
        cfg(1, 1, 0);
        bus_wr(2'd1, 8'h34);
        bus_rd(2'd1, rv); chk("R2 low only", rv, 8'h34);
        cfg(1, 2, 0);
        bus_wr(2'd1, 8'h12);
        bus_rd(2'd1, rv); chk("R2 high only", rv, 8'h12);
        step(1);
        bus_rd(2'd1, rv); chk("R2 high after step", rv, 8'h11);
        cfg(1, 3, 0);
        bus_wr(2'd1, 8'h78);
        bus_wr(2'd1, 8'h56);
        bus_rd(2'd1, rv); chk("R2 pair lo", rv, 8'h78);
        bus_rd(2'd1, rv); chk("R2 pair hi", rv, 8'h56);
        bus_rd(2'd1, rv); chk("R2 pair lo again", rv, 8'h78);
        bus_wr(2'b11, 8'b01_00_000_0);
        bus_rd(2'd1, rv); chk("R2 format 00 ignored", rv, 8'h56);

        // R1: address decode and deselected accesses
        cfg(0, 3, 0); load16(0, 16'h0102);
        cfg(1, 3, 0); load16(1, 16'h0304);
        wr_sel(1'b0, 2'd1, 8'hAA);
        wr_sel(1'b0, 2'd1, 8'hAA);
        bus_rd(2'd1, rv); chk("R1 ch1 lo", rv, 8'h04);
        bus_rd(2'd1, rv); chk("R1 ch1 hi", rv, 8'h03);
        bus_rd(2'd0, rv); chk("R1 ch0 lo", rv, 8'h02);
        bus_rd(2'd3, rv); chk("R1 control reads 0", rv, 8'h00);
        bus_wr(2'b11, 8'b11_11_010_0);
        chk("R1 channel 3 ignored", ch_out[1:0], 2'b00);

        // R10: reprogramming stops a channel
        cfg(0, 3, 0); load16(0, 5);
        step(0); step(0);
        cfg(0, 3, 0);
        chk("R10 mode 0 low", ch_out[0], 1'b0);
        step(0); step(0); step(0);
        bus_rd(2'd0, rv); chk("R10 count frozen", rv, 8'h03);
        cfg(0, 3, 6);
        chk("R10 code 110 high", ch_out[0], 1'b1);
        load16(0, 3);
        step(0);
        chk("R10 code 110 as rate", ch_out[0], 1'b1);
        step(0);
        chk("R10 code 110 pulse", ch_out[0], 1'b0);

        // R11: zero count means 65536
        cfg(0, 3, 0); load16(0, 0);
        step(0);
        bus_rd(2'd0, rv); chk("R11 lo", rv, 8'hFF);
        bus_rd(2'd0, rv); chk("R11 hi", rv, 8'hFF);
        chk("R11 still counting", ch_out[0], 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule